// File: doc/BRIEF.md
# Row Nearest-Feature Distance Sweeper

This block computes the one-dimensional part of a separable Euclidean distance transform, one image row at a time. Each incoming 16-bit pixel is either a marker code (all ones), meaning "no feature here", or any other value, which marks a feature whose code serves as its label. For every pixel the block finds the closest feature in the same row and reports how far away it is and which feature it was.

A row streams in over a valid/ready interface and ends with a last flag. While it arrives, a rightward sweep keeps a running distance and a carried label and parks one packed word per pixel in a single-port row buffer. A leftward sweep then walks the buffer in falling address order. It runs its own distance and label and writes back whichever of the two candidates is nearer. A drain pass finally emits the packed words in pixel order over a second valid/ready stream. Rows with no feature get distances seeded from the configured width plus height, so every result in such a row exceeds the row width and can be recognised as invalid by the stage that follows.

Top module: `row_dist_sweep`

## Requirements
- R1: An input code other than 16'hFFFF is a feature. The output word at a feature's own position is {code[3:0], 12'd0}.
- R2: Each output word packs the label of the chosen feature (the low 4 bits of its code) in bits [15:12] and the horizontal distance in bits [11:0].
- R3: For a row with at least one feature, the distance at pixel i is the smaller of the distances to the nearest feature at or left of i and the nearest feature at or right of i. The label belongs to that feature.
- R4: When the left and right candidates are equally far, the left candidate and its label are output.
- R5: Let S = min(cfg_width + cfg_height, 4095). A side that has no feature yields distance S + (pixels from the row edge up to and including i) and label 0. In a row with no feature, every output distance is therefore larger than cfg_width.
- R6: Distances saturate at 4095 and never carry into the label field.
- R7: A row ends with the pixel that carries in_last. Exactly as many words as pixels are output, in left-to-right order, and out_last is set on the final word only.
- R8: in_ready is low from the cycle after a row's final pixel is accepted until that row's last output word is taken. Input offered in that window is ignored.
- R9: While out_valid is high and out_ready is low, out_data and out_last hold steady.
- R10: A row that reaches 960 pixels (MAX_W) without in_last is ended at its 960th pixel.
- R11: busy rises after a row's first pixel is accepted and falls in the cycle after its last output word is taken. At that point in_ready is high again.
- R12: During and after reset, out_valid and busy are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 12 | Image width, used for the no-feature seed |
| cfg_height | input | 12 | Image height, used for the no-feature seed |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | 16 | Pixel code; 16'hFFFF means no feature |
| in_last | input | 1 | Final pixel of the row |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | {label[3:0], distance[11:0]} |
| out_last | output | 1 | Final word of the row |
| busy | output | 1 | A row is in flight |

## Verification
No output word is due until the whole row has been taken in. The leftward sweep then costs two cycles per pixel, and every drained word needs at least three cycles plus however long out_ready stays low. So the bench does not assume a fixed latency. It samples outputs on the falling edge, counts a word only when a handshake occurs at the next rising edge, and compares that word with the entry in order from a brute-force nearest-feature search. A per-row cycle limit flags a row that never drains. The in_ready and busy flags are checked at the first falling edge after the final input and output handshakes, which is when their registered values must already have changed.

// File: rtl/rds_pkg.sv
package rds_pkg;
  localparam int WORD_W  = 16;
  localparam int DIST_W  = 12;
  localparam int LBL_W   = WORD_W - DIST_W;
  localparam logic [WORD_W-1:0] NO_FEAT  = '1;
  localparam logic [DIST_W-1:0] DIST_TOP = '1;

  typedef enum logic [2:0] {
    ST_FWD, ST_BRD, ST_BWR, ST_DRD, ST_DLD, ST_DOUT
  } rds_state_t;

  function automatic logic [DIST_W-1:0] sat_inc(input logic [DIST_W-1:0] d);
    return (d == DIST_TOP) ? d : d + 1'b1;
  endfunction
endpackage

// File: rtl/rds_row_ram.sv
module rds_row_ram #(
  parameter int DEPTH = 960,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] rd
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      else    rd <= mem[addr];
    end
  end
endmodule

// File: rtl/rds_step.sv
module rds_step
  import rds_pkg::*;
(
  input  logic [DIST_W-1:0] prev_d,
  input  logic [LBL_W-1:0]  prev_l,
  input  logic              feat,
  input  logic [LBL_W-1:0]  feat_l,
  output logic [DIST_W-1:0] nxt_d,
  output logic [LBL_W-1:0]  nxt_l
);
  always_comb begin
    if (feat) begin
      nxt_d = '0;
      nxt_l = feat_l;
    end else begin
      nxt_d = sat_inc(prev_d);
      nxt_l = prev_l;
    end
  end
endmodule

// File: rtl/rds_pick.sv
module rds_pick
  import rds_pkg::*;
(
  input  logic [WORD_W-1:0] fwd_w,
  input  logic [DIST_W-1:0] bwd_d,
  input  logic [LBL_W-1:0]  bwd_l,
  output logic [WORD_W-1:0] best_w
);
  always_comb begin
    if (fwd_w[DIST_W-1:0] <= bwd_d) best_w = fwd_w;
    else                            best_w = {bwd_l, bwd_d};
  end
endmodule

// File: rtl/row_dist_sweep.sv
module row_dist_sweep
  import rds_pkg::*;
#(
  parameter int MAX_W = 960,
  localparam int AW = $clog2(MAX_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIST_W-1:0] cfg_width,
  input  logic [DIST_W-1:0] cfg_height,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              busy
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(MAX_W - 1);

  rds_state_t        state;
  logic [AW-1:0]     ptr, last_idx;
  logic              started;
  logic [DIST_W-1:0] fwd_d, bwd_d, seed_r;
  logic [LBL_W-1:0]  fwd_l, bwd_l;

  // seed for a side with no feature: width + height, clipped
  logic [DIST_W:0]   seed_sum;
  logic [DIST_W-1:0] seed_now, seed_use;
  assign seed_sum = {1'b0, cfg_width} + {1'b0, cfg_height};
  assign seed_now = seed_sum[DIST_W] ? DIST_TOP : seed_sum[DIST_W-1:0];
  assign seed_use = started ? seed_r : seed_now;

  assign in_ready = (state == ST_FWD);
  logic in_hs, row_end;
  assign in_hs   = in_valid && in_ready;
  assign row_end = in_last || (ptr == LAST_ADDR);

  // rightward sweep step
  logic [DIST_W-1:0] fn_d;
  logic [LBL_W-1:0]  fn_l;
  rds_step u_fwd (
    .prev_d (started ? fwd_d : seed_now),
    .prev_l (started ? fwd_l : '0),
    .feat   (in_data != NO_FEAT),
    .feat_l (in_data[LBL_W-1:0]),
    .nxt_d  (fn_d),
    .nxt_l  (fn_l)
  );

  // leftward sweep step, fed from the stored rightward word
  logic [WORD_W-1:0] rd_q, best_w;
  logic [DIST_W-1:0] bn_d;
  logic [LBL_W-1:0]  bn_l;
  rds_step u_bwd (
    .prev_d (bwd_d),
    .prev_l (bwd_l),
    .feat   (rd_q[DIST_W-1:0] == '0),
    .feat_l (rd_q[WORD_W-1:DIST_W]),
    .nxt_d  (bn_d),
    .nxt_l  (bn_l)
  );

  rds_pick u_pick (
    .fwd_w  (rd_q),
    .bwd_d  (bn_d),
    .bwd_l  (bn_l),
    .best_w (best_w)
  );

  logic              ram_en, ram_we;
  logic [WORD_W-1:0] ram_wd;
  always_comb begin
    ram_en = 1'b0;
    ram_we = 1'b0;
    ram_wd = best_w;
    unique case (state)
      ST_FWD: begin ram_en = in_hs; ram_we = 1'b1; ram_wd = {fn_l, fn_d}; end
      ST_BRD: ram_en = 1'b1;
      ST_BWR: begin ram_en = 1'b1; ram_we = 1'b1; end
      ST_DRD: ram_en = 1'b1;
      default: ram_en = 1'b0;
    endcase
  end

  rds_row_ram #(.DEPTH(MAX_W), .WIDTH(WORD_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ptr),
    .wd   (ram_wd),
    .rd   (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FWD;
      ptr       <= '0;
      last_idx  <= '0;
      started   <= 1'b0;
      fwd_d     <= '0;
      fwd_l     <= '0;
      bwd_d     <= '0;
      bwd_l     <= '0;
      seed_r    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      unique case (state)
        ST_FWD: if (in_hs) begin
          started <= 1'b1;
          busy    <= 1'b1;
          seed_r  <= seed_use;
          fwd_d   <= fn_d;
          fwd_l   <= fn_l;
          if (row_end) begin
            last_idx <= ptr;
            bwd_d    <= seed_use;
            bwd_l    <= '0;
            state    <= ST_BRD;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        ST_BRD: state <= ST_BWR;
        ST_BWR: begin
          bwd_d <= bn_d;
          bwd_l <= bn_l;
          if (ptr == '0) state <= ST_DRD;
          else begin
            ptr   <= ptr - 1'b1;
            state <= ST_BRD;
          end
        end
        ST_DRD: state <= ST_DLD;
        ST_DLD: begin
          out_data  <= rd_q;
          out_valid <= 1'b1;
          out_last  <= (ptr == last_idx);
          state     <= ST_DOUT;
        end
        ST_DOUT: if (out_ready) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (ptr == last_idx) begin
            ptr     <= '0;
            started <= 1'b0;
            busy    <= 1'b0;
            state   <= ST_FWD;
          end else begin
            ptr   <= ptr + 1'b1;
            state <= ST_DRD;
          end
        end
        default: state <= ST_FWD;
      endcase
    end
  end
endmodule

// File: rtl/rds_checker.sv
module rds_checker
  import rds_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last,
  input logic              busy
);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_no_input_while_draining: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid);

  a_r11_busy_ends_on_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(out_valid && out_ready && out_last));

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r12_idle_accepts: assert property (@(posedge clk) disable iff (rst)
    !busy |-> in_ready);
endmodule

bind row_dist_sweep rds_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .busy      (busy)
);

// File: tb/row_dist_sweep_tb.sv
`timescale 1ns/1ps
module row_dist_sweep_tb;
  localparam int MAXW = 960;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_width = '0, cfg_height = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, out_valid, out_last, busy;
  logic [15:0] out_data;

  always #10 clk = ~clk;

  row_dist_sweep u_dut (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] pix  [MAXW];
  logic [15:0] want [MAXW];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // brute-force nearest feature in the row (R3 R4 R5 R6)
  task automatic build_expect(input int n);
    int s = int'(cfg_width) + int'(cfg_height);
    if (s > 4095) s = 4095;
    for (int i = 0; i < n; i++) begin
      int ld = -1, rd = -1;
      logic [3:0] ll = 4'd0, rl = 4'd0;
      for (int j = i; j >= 0; j--)
        if (pix[j] != 16'hFFFF) begin ld = i - j; ll = pix[j][3:0]; break; end
      for (int j = i; j < n; j++)
        if (pix[j] != 16'hFFFF) begin rd = j - i; rl = pix[j][3:0]; break; end
      if (ld < 0) begin ld = s + i + 1; if (ld > 4095) ld = 4095; end
      if (rd < 0) begin rd = s + (n - i); if (rd > 4095) rd = 4095; end
      if (ld <= rd) want[i] = {ll, 12'(ld)};
      else          want[i] = {rl, 12'(rd)};
    end
  endtask

  task automatic run_row(input int n, input bit use_last, input string tag);
    int got = 0, guard = 0;
    bit pend = 1'b0;
    logic [15:0] pd;
    logic pl;
    build_expect(n);
    for (int i = 0; i < n; i++) begin
      bit hs = 1'b0;
      repeat ($urandom % 3) begin @(negedge clk); in_valid = 1'b0; end
      while (!hs) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = pix[i];
        in_last  = use_last && (i == n - 1);
        hs = in_ready;
        if (i == 1 && hs) chk(busy == 1'b1, "R11 busy after first pixel", busy, 1);
        @(posedge clk);
      end
    end
    // offer a stray feature pixel while the row is in flight
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 in_ready low after row end", in_ready, 0);
    in_valid = 1'b1; in_data = 16'h0001; in_last = 1'b1;
    while (got < n && guard < 20000) begin
      guard++;
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (pend) begin
        chk(out_valid && out_data == pd && out_last == pl, "R9 hold while stalled",
            {15'd0, out_valid, out_data}, {16'd1, pd});
        pend = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          chk(out_data == want[got], tag, out_data, want[got]);
          chk(out_last == (got == n - 1), "R7 out_last placement", out_last, got == n - 1);
          got++;
        end else begin
          pend = 1'b1; pd = out_data; pl = out_last;
        end
      end
      @(posedge clk);
    end
    if (got < n) chk(1'b0, "R7 row did not drain", got, n);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    chk(busy == 1'b0 && in_ready == 1'b1, "R11 idle after drain", {busy, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !busy && in_ready, "R12 reset state", {out_valid, busy, in_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !busy && in_ready, "R12 after reset", {out_valid, busy, in_ready}, 3'b001);

    // R2: one feature in the middle
    cfg_width = 12'd8; cfg_height = 12'd4;
    for (int i = 0; i < 8; i++) pix[i] = 16'hFFFF;
    pix[3] = 16'h12A7;
    run_row(8, 1'b1, "R2 packed label and distance");

    // R4: features at both ends, tie in the middle
    cfg_width = 12'd9;
    for (int i = 0; i < 9; i++) pix[i] = 16'hFFFF;
    pix[0] = 16'h0003; pix[8] = 16'h0005;
    run_row(9, 1'b1, "R4 tie keeps left");

    // R5: no feature at all
    cfg_width = 12'd12; cfg_height = 12'd5;
    for (int i = 0; i < 12; i++) pix[i] = 16'hFFFF;
    run_row(12, 1'b1, "R5 no-feature row");

    // R6: saturation of the seed plus count
    cfg_width = 12'd4000; cfg_height = 12'd90;
    for (int i = 0; i < 10; i++) pix[i] = 16'hFFFF;
    run_row(10, 1'b1, "R6 saturated distance");
    cfg_width = 12'd3000; cfg_height = 12'd3000;
    run_row(6, 1'b1, "R6 saturated seed");

    // R1: all features, and single-pixel rows
    cfg_width = 12'd16; cfg_height = 12'd16;
    for (int i = 0; i < 16; i++) pix[i] = 16'(i * 16'h1111 + 16'h0100);
    pix[15] = 16'hFFFE;
    run_row(16, 1'b1, "R1 every pixel a feature");
    pix[0] = 16'h000C;
    run_row(1, 1'b1, "R1 single feature pixel");
    pix[0] = 16'hFFFF;
    run_row(1, 1'b1, "R5 single empty pixel");

    // R10: full-width row with no last flag
    cfg_width = 12'd960; cfg_height = 12'd540;
    for (int i = 0; i < MAXW; i++)
      pix[i] = ($urandom % 40 == 0) ? 16'($urandom % 16'hFFFF) : 16'hFFFF;
    run_row(MAXW, 1'b0, "R10 row closed at max width");

    // R3: random rows
    for (int r = 0; r < 25; r++) begin
      int n = 1 + ($urandom % 120);
      cfg_width = 12'(n); cfg_height = 12'($urandom % 200);
      for (int i = 0; i < n; i++)
        pix[i] = ($urandom % 8 == 0) ? 16'($urandom % 16'hFFFF) : 16'hFFFF;
      run_row(n, 1'b1, "R3 nearest feature random row");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule